// File: doc/BRIEF.md
# Streaming FIFO Slot Arbiter

This block connects one processor core to a shared memory whose access windows rotate among banks. A free-running counter names the bank that owns the current cycle. An access is carried out only when the low address bits of the request equal that bank number. The block holds one word FIFO. A restart points the FIFO at a base address and sets its direction. In read mode it fetches consecutive words from memory for the core to pop. In write mode it stores the words the core pushes to consecutive addresses.

The core can also issue single direct reads and writes. In any cycle only one access can use the slot, so the block chooses between FIFO traffic and the pending direct access. In hardware-streaming use the FIFO has first claim, because its consumer is a real-time output. In software use the direct access goes first. A configuration override can force either policy.

Memory returns read data in the cycle after the access. Encodings: `fifo_write` = 1 makes memory the destination and 0 makes memory the source. `cfg_sw_mode` = 1 selects software use and 0 selects hardware streaming.

Top module: `stream_slot_arbiter`

## Requirements
- R1: While reset is held: `slot_bank` is 0, `mem_en` is 0, `dir_done` is 0, `fifo_avail` is 0, and `dir_busy` is 0 when no request is present.
- R2: After reset, `slot_bank` increases by one every cycle, modulo 2^BANK_W.
- R3: For every memory access, bits [BANK_W-1:0] of `mem_addr` equal `slot_bank` in that cycle.
- R4: A direct request keeps `dir_busy` high until its slot is used. `dir_done` then pulses for exactly one cycle, two cycles after the access cycle. A read returns the addressed word on `dir_rdata`. A write updates memory.
- R5: With `cfg_override`=0 and `cfg_sw_mode`=0, the FIFO takes any slot that both the FIFO and the direct access could use. The direct access waits for the next matching slot.
- R6: With `cfg_override`=0 and `cfg_sw_mode`=1, the direct access takes a contested slot and the FIFO waits.
- R7: With `cfg_override`=1, `cfg_fifo_first` alone decides the winner of a contested slot, in either mode.
- R8: In read mode, popped words come from consecutive ascending addresses starting at `fifo_base`. A FIFO fetch is issued only while held words plus in-flight words are fewer than REFILL_LVL.
- R9: In write mode, pushed words are written to consecutive ascending addresses from `fifo_base`, in push order. A word is drained whenever at least one is held and the slot matches.
- R10: The FIFO works in one direction at a time: write mode issues only memory writes and read mode issues only memory reads.
- R11: A restart empties the FIFO and discards any in-flight fetch. The first word from the new base is available within 2^BANK_W+3 cycles of the restart pulse.
- R12: A pop while empty, or a push while full, raises `fifo_stall`. No word is returned or dropped, and the operation completes once it can.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_sw_mode | input | 1 | 1 = software use, 0 = hardware streaming |
| cfg_override | input | 1 | 1 = use cfg_fifo_first instead of the mode default |
| cfg_fifo_first | input | 1 | forced policy: 1 = FIFO wins a contested slot |
| fifo_start | input | 1 | restart pulse |
| fifo_write | input | 1 | direction captured at restart (1 = to memory) |
| fifo_base | input | AW | base address captured at restart |
| fifo_pop | input | 1 | core takes the head word (read mode) |
| fifo_push | input | 1 | core offers a word (write mode) |
| fifo_wdata | input | DW | word offered by the core |
| fifo_rdata | output | DW | head word of the FIFO |
| fifo_avail | output | 1 | a word is ready to pop |
| fifo_stall | output | 1 | pop or push cannot complete this cycle |
| dir_req | input | 1 | direct access request, held until done |
| dir_we | input | 1 | 1 = direct write |
| dir_addr | input | AW | direct address |
| dir_wdata | input | DW | direct write data |
| dir_busy | output | 1 | direct request waiting |
| dir_done | output | 1 | one-cycle completion pulse |
| dir_rdata | output | DW | direct read result |
| slot_bank | output | BANK_W | bank owning the current slot |
| mem_en | output | 1 | memory access this cycle |
| mem_we | output | 1 | access is a write |
| mem_addr | output | AW | access address |
| mem_wdata | output | DW | write data |
| mem_rdata | input | DW | read data, one cycle after the access |

## Verification
Every cycle, the checks cover the bank step, the address-to-bank match of each access, and the single-cycle done pulse. They also cover the contested-slot winner for each configuration, the direction of FIFO traffic, the occupancy bound, and the empty state after a restart. Some behaviour shows only in the bench's scenarios. This includes the data order of streamed words and the refill threshold measured as a count of fetches. It also includes the 16-cycle shift that a lost slot causes, the restart latency, and the push stall at a full FIFO together with the later completion of that push.

// File: rtl/stream_arb_pkg.sv
package stream_arb_pkg;

    typedef enum logic {
        USE_HW = 1'b0,
        USE_SW = 1'b1
    } use_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_FIFO   = 2'd1,
        SRC_DIRECT = 2'd2
    } slot_src_e;

    typedef enum logic [1:0] {
        DP_IDLE   = 2'd0,
        DP_FLIGHT = 2'd1,
        DP_DONE   = 2'd2,
        DP_HOLD   = 2'd3
    } dp_state_e;

    typedef struct packed {
        slot_src_e src;
        logic      fifo_first;
        logic      clash;
    } slot_pick_t;

    // Winner policy for a contested slot.
    function automatic logic fifo_goes_first(use_mode_e mode, logic ovr, logic ovr_val);
        return ovr ? ovr_val : (mode == USE_HW);
    endfunction

endpackage

// File: rtl/slot_rotor.sv
module slot_rotor #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [BANK_W-1:0] bank
);
    always_ff @(posedge clk) begin
        if (rst) bank <= '0;
        else     bank <= bank + 1'b1;
    end
endmodule

// File: rtl/word_ring.sv
module word_ring #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DW-1:0]              wdata,
    input  logic                       pop,
    output logic [DW-1:0]              head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] rd_p, wr_p;

    function automatic logic [PW-1:0] step(logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = store[rd_p];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (push) store[wr_p] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_p  <= '0;
            wr_p  <= '0;
            count <= '0;
        end else begin
            if (push) wr_p <= step(wr_p);
            if (pop)  rd_p <= step(rd_p);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/slot_policy.sv
module slot_policy
    import stream_arb_pkg::*;
(
    input  logic       sw_mode,
    input  logic       ovr,
    input  logic       ovr_fifo_first,
    input  logic       fifo_want,
    input  logic       dir_want,
    output slot_pick_t pick
);
    always_comb begin
        pick.fifo_first = fifo_goes_first(use_mode_e'(sw_mode), ovr, ovr_fifo_first);
        pick.clash      = fifo_want & dir_want;
        if (fifo_want && (!dir_want || pick.fifo_first))
            pick.src = SRC_FIFO;
        else if (dir_want)
            pick.src = SRC_DIRECT;
        else
            pick.src = SRC_NONE;
    end
endmodule

// File: rtl/direct_port.sv
module direct_port
    import stream_arb_pkg::*;
#(
    parameter int DW     = 32,
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [BANK_W-1:0] addr_bank,
    input  logic [BANK_W-1:0] bank,
    input  logic              granted,
    input  logic [DW-1:0]     mem_rdata,
    output logic              want,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     rdata
);
    dp_state_e st;

    assign want = (st == DP_IDLE) && req && (addr_bank == bank);
    assign busy = req && (st == DP_IDLE || st == DP_FLIGHT);
    assign done = (st == DP_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= DP_IDLE;
            rdata <= '0;
        end else begin
            case (st)
                DP_IDLE:   if (granted) st <= DP_FLIGHT;
                DP_FLIGHT: begin
                    rdata <= mem_rdata;
                    st    <= DP_DONE;
                end
                DP_DONE:   st <= req ? DP_HOLD : DP_IDLE;
                default:   if (!req) st <= DP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/stream_slot_arbiter.sv
module stream_slot_arbiter
    import stream_arb_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int DEPTH      = 16,
    parameter int REFILL_LVL = 8,
    parameter int BANK_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_sw_mode,
    input  logic              cfg_override,
    input  logic              cfg_fifo_first,
    input  logic              fifo_start,
    input  logic              fifo_write,
    input  logic [AW-1:0]     fifo_base,
    input  logic              fifo_pop,
    input  logic              fifo_push,
    input  logic [DW-1:0]     fifo_wdata,
    output logic [DW-1:0]     fifo_rdata,
    output logic              fifo_avail,
    output logic              fifo_stall,
    input  logic              dir_req,
    input  logic              dir_we,
    input  logic [AW-1:0]     dir_addr,
    input  logic [DW-1:0]     dir_wdata,
    output logic              dir_busy,
    output logic              dir_done,
    output logic [DW-1:0]     dir_rdata,
    output logic [BANK_W-1:0] slot_bank,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata
);
    localparam int CW = $clog2(DEPTH+1);

    logic          act_q, wr_q, infl_q;
    logic [AW-1:0] ptr_q;
    logic [CW-1:0] cnt;
    logic          empty, full;
    logic [DW-1:0] head;
    logic [CW:0]   occ;
    logic          fifo_need, fifo_want, dir_want;
    logic          fifo_go, dir_go;
    logic          rpush, rpop;
    logic [DW-1:0] rin;
    slot_pick_t    pick;

    slot_rotor #(.BANK_W(BANK_W)) u_rotor (
        .clk(clk), .rst(rst), .bank(slot_bank)
    );

    word_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst(rst), .flush(fifo_start),
        .push(rpush), .wdata(rin), .pop(rpop),
        .head(head), .count(cnt), .empty(empty), .full(full)
    );

    direct_port #(.DW(DW), .BANK_W(BANK_W)) u_direct (
        .clk(clk), .rst(rst), .req(dir_req),
        .addr_bank(dir_addr[BANK_W-1:0]), .bank(slot_bank),
        .granted(dir_go), .mem_rdata(mem_rdata),
        .want(dir_want), .busy(dir_busy), .done(dir_done), .rdata(dir_rdata)
    );

    slot_policy u_policy (
        .sw_mode(cfg_sw_mode), .ovr(cfg_override), .ovr_fifo_first(cfg_fifo_first),
        .fifo_want(fifo_want), .dir_want(dir_want), .pick(pick)
    );

    // Occupancy counts words already held plus a fetch still returning.
    assign occ       = {1'b0, cnt} + {{CW{1'b0}}, infl_q};
    assign fifo_need = act_q && !fifo_start &&
                       (wr_q ? !empty : (occ < (CW+1)'(REFILL_LVL)));
    assign fifo_want = fifo_need && (ptr_q[BANK_W-1:0] == slot_bank);
    assign fifo_go   = (pick.src == SRC_FIFO);
    assign dir_go    = (pick.src == SRC_DIRECT);

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (fifo_go) begin
            mem_en    = 1'b1;
            mem_we    = wr_q;
            mem_addr  = ptr_q;
            mem_wdata = head;
        end else if (dir_go) begin
            mem_en    = 1'b1;
            mem_we    = dir_we;
            mem_addr  = dir_addr;
            mem_wdata = dir_wdata;
        end
    end

    // Ring traffic: the source and the sink swap with the direction.
    assign rpush = wr_q ? (fifo_push && act_q && !full && !fifo_start)
                        : (infl_q && !fifo_start);
    assign rin   = wr_q ? fifo_wdata : mem_rdata;
    assign rpop  = wr_q ? fifo_go : (fifo_pop && !empty && !fifo_start);

    assign fifo_rdata = head;
    assign fifo_avail = !wr_q && !empty;
    assign fifo_stall = (fifo_pop && !wr_q && empty) || (fifo_push && wr_q && full);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            wr_q   <= 1'b0;
            infl_q <= 1'b0;
            ptr_q  <= '0;
        end else if (fifo_start) begin
            act_q  <= 1'b1;
            wr_q   <= fifo_write;
            infl_q <= 1'b0;
            ptr_q  <= fifo_base;
        end else begin
            infl_q <= fifo_go && !wr_q;
            if (fifo_go) ptr_q <= ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/stream_slot_arbiter_chk.sv
module stream_slot_arbiter_chk #(
    parameter int BANK_W = 4,
    parameter int DEPTH  = 16,
    parameter int CW     = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [BANK_W-1:0] slot_bank,
    input logic              mem_en,
    input logic              mem_we,
    input logic [BANK_W-1:0] mem_addr_lo,
    input logic              dir_done,
    input logic              dir_busy,
    input logic              cfg_sw_mode,
    input logic              cfg_override,
    input logic              cfg_fifo_first,
    input logic              clash,
    input logic              fifo_go,
    input logic              wr_q,
    input logic              fifo_start,
    input logic [CW-1:0]     cnt
);
    // R2
    bank_step_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> slot_bank == BANK_W'($past(slot_bank) + 1'b1));
    // R3
    slot_match_chk: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> mem_addr_lo == slot_bank);
    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        dir_done |=> !dir_done);
    // R4
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        dir_done |-> !dir_busy);
    // R5
    hw_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (clash && !cfg_override && !cfg_sw_mode) |-> fifo_go);
    // R6
    sw_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (clash && !cfg_override && cfg_sw_mode) |-> !fifo_go);
    // R7
    ovr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (clash && cfg_override) |-> fifo_go == cfg_fifo_first);
    // R10
    one_way_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_go |-> mem_en && (mem_we == wr_q));
    // R11
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_start |=> cnt == '0);
    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
endmodule

bind stream_slot_arbiter stream_slot_arbiter_chk #(
    .BANK_W(BANK_W), .DEPTH(DEPTH), .CW($clog2(DEPTH+1))
) u_chk (
    .clk(clk), .rst(rst), .slot_bank(slot_bank),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr_lo(mem_addr[BANK_W-1:0]),
    .dir_done(dir_done), .dir_busy(dir_busy),
    .cfg_sw_mode(cfg_sw_mode), .cfg_override(cfg_override),
    .cfg_fifo_first(cfg_fifo_first), .clash(pick.clash),
    .fifo_go(fifo_go), .wr_q(wr_q), .fifo_start(fifo_start), .cnt(cnt)
);

// File: tb/sim_stream_slot_arbiter.sv
`timescale 1ns/1ps
module sim_stream_slot_arbiter;
    localparam int AW = 8, DW = 32, DEPTH = 4, RL = 2, BW = 4, BANKS = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_sw = 1'b0, cfg_ovr = 1'b0, cfg_ff = 1'b0;
    logic fifo_start = 1'b0, fifo_write = 1'b0;
    logic [AW-1:0] fifo_base = '0;
    logic fifo_pop = 1'b0, fifo_push = 1'b0;
    logic [DW-1:0] fifo_wdata = '0, fifo_rdata;
    logic fifo_avail, fifo_stall;
    logic dir_req = 1'b0, dir_we = 1'b0;
    logic [AW-1:0] dir_addr = '0;
    logic [DW-1:0] dir_wdata = '0, dir_rdata;
    logic dir_busy, dir_done;
    logic [BW-1:0] slot_bank;
    logic mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    int total = 0, bad = 0, cyc = 0;
    int rd_n = 0, wr_n = 0, slot_err = 0, step_err = 0;
    int acc [0:255];
    logic [DW-1:0] mem [0:255];
    logic [BW-1:0] prev_bank = '0;
    bit have_prev = 1'b0;

    stream_slot_arbiter #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .REFILL_LVL(RL), .BANK_W(BW)) u0 (
        .clk(clk), .rst(rst), .cfg_sw_mode(cfg_sw), .cfg_override(cfg_ovr),
        .cfg_fifo_first(cfg_ff), .fifo_start(fifo_start), .fifo_write(fifo_write),
        .fifo_base(fifo_base), .fifo_pop(fifo_pop), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .fifo_rdata(fifo_rdata), .fifo_avail(fifo_avail),
        .fifo_stall(fifo_stall), .dir_req(dir_req), .dir_we(dir_we), .dir_addr(dir_addr),
        .dir_wdata(dir_wdata), .dir_busy(dir_busy), .dir_done(dir_done),
        .dir_rdata(dir_rdata), .slot_bank(slot_bank), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] pat(int a);
        return {8'hC3, 8'(a), 8'(a * 3), 8'(~a)};
    endfunction

    // Memory model: registered read, one cycle of latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            for (int a = 0; a < 256; a++) mem[a] <= pat(a);
        end else if (mem_en) begin
            mem_rdata <= mem[mem_addr];
            if (mem_we) mem[mem_addr] <= mem_wdata;
        end
    end

    // Port monitor, sampling after the bench's negedge drives settle.
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (have_prev && slot_bank != BW'(prev_bank + 1'b1)) step_err++;
            prev_bank = slot_bank;
            have_prev = 1'b1;
            if (mem_en) begin
                acc[mem_addr] = cyc;
                if (mem_we) wr_n++; else rd_n++;
                if (mem_addr[BW-1:0] != slot_bank) slot_err++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_bank(input int b);
        @(negedge clk);
        while (slot_bank != BW'(b)) @(negedge clk);
    endtask

    task automatic restart(input bit wr, input int base);
        fifo_start = 1'b1; fifo_write = wr; fifo_base = AW'(base);
        @(negedge clk);
        fifo_start = 1'b0;
    endtask

    task automatic pop_word(output logic [DW-1:0] d);
        fifo_pop = 1'b1;
        #1;
        while (fifo_stall) begin @(negedge clk); #1; end
        d = fifo_rdata;
        @(negedge clk);
        fifo_pop = 1'b0;
    endtask

    task automatic push_word(input logic [DW-1:0] d);
        fifo_push = 1'b1; fifo_wdata = d;
        #1;
        while (fifo_stall) begin @(negedge clk); #1; end
        @(negedge clk);
        fifo_push = 1'b0;
    endtask

    task automatic dir_op(input bit we, input int a, input logic [DW-1:0] wd, output logic [DW-1:0] rd);
        dir_req = 1'b1; dir_we = we; dir_addr = AW'(a); dir_wdata = wd;
        #1;
        chk(dir_busy == 1'b1, "R4 busy while waiting", dir_busy, 1);
        while (!dir_done) @(negedge clk);
        rd = dir_rdata;
        dir_req = 1'b0;
        @(negedge clk);
    endtask

    // Contested slot at bank 0: FIFO base 0x20 against direct read 0x50.
    task automatic prio_run(input bit sw, input bit ovr, input bit ff, input int exp_diff, input string req);
        int done_c;
        logic [DW-1:0] rd;
        cfg_sw = sw; cfg_ovr = ovr; cfg_ff = ff;
        acc[8'h20] = -1000; acc[8'h50] = -1000;
        wait_bank(5);
        fifo_start = 1'b1; fifo_write = 1'b0; fifo_base = 8'h20;
        dir_req = 1'b1; dir_we = 1'b0; dir_addr = 8'h50;
        @(negedge clk);
        fifo_start = 1'b0;
        while (!dir_done) @(negedge clk);
        done_c = cyc; rd = dir_rdata; dir_req = 1'b0;
        repeat (20) @(negedge clk);
        chk(acc[8'h50] - acc[8'h20] == exp_diff, req, acc[8'h50] - acc[8'h20], exp_diff);
        chk(done_c - acc[8'h50] == 2, "R4 done two cycles after access", done_c - acc[8'h50], 2);
        chk(rd == pat(8'h50), "R4 direct read data", rd, pat(8'h50));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        int t0, rd0;
        for (int a = 0; a < 256; a++) acc[a] = -1000;
        repeat (4) @(negedge clk);
        #1;
        // R1
        chk(slot_bank == 0, "R1 bank in reset", slot_bank, 0);
        chk(mem_en == 0, "R1 no access in reset", mem_en, 0);
        chk(dir_done == 0 && dir_busy == 0, "R1 direct idle", {dir_done, dir_busy}, 0);
        chk(fifo_avail == 0, "R1 fifo empty", fifo_avail, 0);
        @(negedge clk);
        rst = 1'b0;

        // R5, R6, R7: winner of the contested slot shifts the loser by one rotation.
        prio_run(1'b0, 1'b0, 1'b0,  16, "R5 hw default fifo first");
        prio_run(1'b1, 1'b0, 1'b0, -16, "R6 sw default direct first");
        prio_run(1'b0, 1'b1, 1'b0, -16, "R7 override direct first in hw");
        prio_run(1'b1, 1'b1, 1'b1,  16, "R7 override fifo first in sw");

        // R8: refill stops at RL words.
        cfg_sw = 1'b0; cfg_ovr = 1'b0;
        @(negedge clk);
        rd0 = rd_n;
        restart(1'b0, 8'h90);
        repeat (40) @(negedge clk);
        chk(rd_n - rd0 == RL, "R8 fetches capped at refill level", rd_n - rd0, RL);
        pop_word(d);
        chk(d == pat(8'h90), "R8 first word", d, pat(8'h90));
        repeat (40) @(negedge clk);
        chk(rd_n - rd0 == RL + 1, "R8 one refill after pop", rd_n - rd0, RL + 1);

        // R8: streamed order.
        restart(1'b0, 8'h40);
        for (int i = 0; i < 10; i++) begin
            pop_word(d);
            chk(d == pat(8'h40 + i), "R8 stream order", d, pat(8'h40 + i));
        end

        // R11 and R12: restart flushes, pop on empty stalls, latency bound.
        restart(1'b0, 8'h40);
        repeat (30) @(negedge clk);
        fifo_start = 1'b1; fifo_base = 8'hA0; fifo_write = 1'b0;
        t0 = cyc;
        @(negedge clk);
        fifo_start = 1'b0;
        fifo_pop = 1'b1;
        #1;
        chk(fifo_stall == 1'b1, "R12 pop on empty stalls", fifo_stall, 1);
        while (fifo_stall) begin @(negedge clk); #1; end
        d = fifo_rdata;
        chk(cyc - t0 <= BANKS + 3, "R11 first word latency", cyc - t0, BANKS + 3);
        @(negedge clk);
        fifo_pop = 1'b0;
        chk(d == pat(8'hA0), "R11 first word from new base", d, pat(8'hA0));

        // R9, R10: write stream.
        rd0 = rd_n;
        restart(1'b1, 8'h60);
        for (int i = 0; i < 6; i++) push_word(32'hD00D_0000 + 32'(i * 7));
        repeat (50) @(negedge clk);
        for (int i = 0; i < 6; i++)
            chk(mem[8'h60 + i] == 32'hD00D_0000 + 32'(i * 7), "R9 write order",
                mem[8'h60 + i], 32'hD00D_0000 + 32'(i * 7));
        chk(rd_n == rd0, "R10 write mode issues no reads", rd_n - rd0, 0);

        // R12: push on full stalls and completes later.
        wait_bank(3);
        restart(1'b1, 8'h72);
        for (int i = 0; i < 4; i++) begin
            fifo_push = 1'b1; fifo_wdata = 32'hBEE0_0000 + 32'(i * 17);
            @(negedge clk);
        end
        fifo_push = 1'b1; fifo_wdata = 32'hBEE0_0000 + 32'(4 * 17);
        #1;
        chk(fifo_stall == 1'b1, "R12 push on full stalls", fifo_stall, 1);
        while (fifo_stall) begin @(negedge clk); #1; end
        @(negedge clk);
        fifo_push = 1'b0;
        repeat (40) @(negedge clk);
        for (int i = 0; i < 5; i++)
            chk(mem[8'h72 + i] == 32'hBEE0_0000 + 32'(i * 17), "R12 no word dropped",
                mem[8'h72 + i], 32'hBEE0_0000 + 32'(i * 17));

        // R4: direct write then read back.
        cfg_sw = 1'b1;
        dir_op(1'b1, 8'h33, 32'hCAFE_0033, d);
        chk(mem[8'h33] == 32'hCAFE_0033, "R4 direct write", mem[8'h33], 32'hCAFE_0033);
        dir_op(1'b0, 8'h33, '0, d);
        chk(d == 32'hCAFE_0033, "R4 direct read back", d, 32'hCAFE_0033);

        chk(slot_err == 0, "R3 access bank match", slot_err, 0);
        chk(step_err == 0, "R2 bank rotation", step_err, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule